// File: doc/BRIEF.md
# SHA-512 Two-Round Sigma1/Choose Unit

This unit computes the Sigma1-plus-choose portion of two back-to-back SHA-512 compression rounds in one lane-packed 128-bit operation. It takes three 128-bit operands: `inX` and `inY`, which carry hash words, and `inW`, which carries per-round running sums of state, schedule word and round constant. Each operand is split into an upper 64-bit lane [127:64] and a lower 64-bit lane [63:0]. The unit returns a single 128-bit result. The upper lane is produced by the first half-round. The lower lane is produced by a second half-round that depends on the first.

The work is split across two pipeline stages. The boundary sits right after the intermediate sum `tmp` (upper result plus the lower lane of `inY`). The first stage registers the upper result and `tmp`, together with the operand lanes that the second stage still needs. The second stage finishes the lower lane and presents both lanes together.

The pipeline advances as one unit whenever the consumer is ready. Input acceptance therefore follows the output ready. A result appears two clock edges after its input handshake, provided the consumer stays ready. The unit keeps no status or condition flags of any kind.

Top module: `sha2r_sigch_top`

## Requirements
- R1: Result bits [127:64] equal (ch1 + S1(inY[127:64]) + inW[127:64]) mod 2^64. Here ch1 = (inY[127:64] AND inX[63:0]) XOR (NOT inY[127:64] AND inX[127:64]).
- R2: S1(v) is the XOR of v rotated right by 14, by 18 and by 41 bit positions.
- R3: In the first choose, each bit takes inX[63:0] where the selector bit inY[127:64] is 1, and inX[127:64] where it is 0.
- R4: tmp = (result[127:64] + inY[63:0]) mod 2^64. The second choose is ch2 = (tmp AND inY[127:64]) XOR (NOT tmp AND inX[63:0]).
- R5: Result bits [63:0] equal (ch2 + S1(tmp) + inW[63:0]) mod 2^64. No carry crosses between the two lanes.
- R6: An input is accepted on a rising edge where inValid and inReady are both 1. If outReady stays 1, outValid is 1 after the second following rising edge, and outData then holds that input's result.
- R7: inReady equals outReady. While outReady is 0, inValid pulses are not accepted, and no result later appears for them.
- R8: While outValid is 1 and outReady is 0, outValid and outData stay unchanged.
- R9: A synchronous active-high rst clears outValid and any result in flight. After reset, outData reads all zeros.
- R10: outData holds its value through cycles where no new result arrives, including after outValid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands on inX/inY/inW are valid |
| inReady | output | 1 | Unit can take operands this cycle |
| inX | input | 128 | Hash words operand (two lanes) |
| inY | input | 128 | Hash words operand, supplies selectors and Sigma1 input |
| inW | input | 128 | Running-sum operand added into each lane |
| outValid | output | 1 | outData holds a fresh result |
| outReady | input | 1 | Consumer takes the result; also advances the pipeline |
| outData | output | 128 | Two-lane result, upper lane from first round |

## Verification
The bench drives operands in which both lanes' sums wrap past 2^64. It checks the lower lane against a model that keeps the lanes separate, so any carry leaking across bit 64 shows up immediately. Selector patterns are chosen so that swapping the two choose sources, or feeding the wrong lane into the second choose or into tmp, changes the result. Handshake scenarios cover three cases: a stall while holding a result, pulses of inValid while ready is low, and a bubble after a stream. A design that let data slip while stalled, accepted ghost inputs or wiped outData when valid falls would fail these.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;

  // Strobes handed from the pipeline control to the datapath.
  typedef struct packed {
    logic loadS1;   // capture first-round results into stage 1
    logic loadOut;  // capture the finished word into the output register
  } pipeStrobe_t;

  localparam int DEF_LANE_W = 64;
  localparam int DEF_ROT_A  = 14;
  localparam int DEF_ROT_B  = 18;
  localparam int DEF_ROT_C  = 41;

endpackage

// File: rtl/sha2r_sigma1.sv
module sha2r_sigma1 #(
  parameter int LANE_W = 64,
  parameter int ROT_A  = 14,
  parameter int ROT_B  = 18,
  parameter int ROT_C  = 41
) (
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int NUM_ROT = 3;
  localparam int ROT_AMT [NUM_ROT] = '{ROT_A, ROT_B, ROT_C};

  logic [2*LANE_W-1:0] doubled;
  logic [LANE_W-1:0]   rotated [NUM_ROT];

  assign doubled = {din, din};

  // Right rotation by r is a window into the word concatenated with itself.
  for (genvar g = 0; g < NUM_ROT; g++) begin : g_rot
    assign rotated[g] = doubled[ROT_AMT[g] +: LANE_W];
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < NUM_ROT; k++) dout = dout ^ rotated[k];
  end
endmodule

// File: rtl/sha2r_ctrl.sv
module sha2r_ctrl
  import sha2r_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output pipeStrobe_t strobe
);
  logic s1Valid;

  // The whole pipe moves when the consumer is ready.
  always_comb begin
    inReady        = outReady;
    strobe.loadS1  = outReady & inValid;
    strobe.loadOut = outReady & s1Valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else if (outReady) begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end
endmodule

// File: rtl/sha2r_datapath.sv
module sha2r_datapath
  import sha2r_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int ROT_A  = 14,
  parameter int ROT_B  = 18,
  parameter int ROT_C  = 41,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  pipeStrobe_t       strobe,
  input  logic [WORD_W-1:0] inX,
  input  logic [WORD_W-1:0] inY,
  input  logic [WORD_W-1:0] inW,
  output logic [WORD_W-1:0] outData
);
  typedef logic [LANE_W-1:0] lane_t;

  // Stage-0 lane split.
  lane_t xHi, xLo, yHi, yLo, wHi, wLo;
  assign {xHi, xLo} = inX;
  assign {yHi, yLo} = inY;
  assign {wHi, wLo} = inW;

  // First half-round.
  lane_t sigA, chooseA, sumHi, tmpSum;

  sha2r_sigma1 #(.LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C))
    u_sigmaA (.din(yHi), .dout(sigA));

  always_comb begin
    chooseA = (yHi & xLo) ^ (~yHi & xHi);
    sumHi   = chooseA + sigA + wHi;
    tmpSum  = sumHi + yLo;
  end

  // Stage-1 registers.
  lane_t s1Hi, s1Tmp, s1XLo, s1YHi, s1WLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Hi  <= '0;
      s1Tmp <= '0;
      s1XLo <= '0;
      s1YHi <= '0;
      s1WLo <= '0;
    end else if (strobe.loadS1) begin
      s1Hi  <= sumHi;
      s1Tmp <= tmpSum;
      s1XLo <= xLo;
      s1YHi <= yHi;
      s1WLo <= wLo;
    end
  end

  // Second half-round, driven by the intermediate sum.
  lane_t sigB, chooseB, sumLo;

  sha2r_sigma1 #(.LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C))
    u_sigmaB (.din(s1Tmp), .dout(sigB));

  always_comb begin
    chooseB = (s1Tmp & s1YHi) ^ (~s1Tmp & s1XLo);
    sumLo   = chooseB + sigB + s1WLo;
  end

  always_ff @(posedge clk) begin
    if (rst)                 outData <= '0;
    else if (strobe.loadOut) outData <= {s1Hi, sumLo};
  end
endmodule

// File: rtl/sha2r_sigch_top.sv
module sha2r_sigch_top
  import sha2r_pkg::*;
#(
  parameter int LANE_W = DEF_LANE_W,
  parameter int ROT_A  = DEF_ROT_A,
  parameter int ROT_B  = DEF_ROT_B,
  parameter int ROT_C  = DEF_ROT_C,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inX,
  input  logic [WORD_W-1:0] inY,
  input  logic [WORD_W-1:0] inW,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData
);
  pipeStrobe_t strobe;

  sha2r_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  sha2r_datapath #(.LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C))
    u_dp (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .inX    (inX),
      .inY    (inY),
      .inW    (inW),
      .outData(outData)
    );
endmodule

// File: rtl/sha2r_sigch_chk.sv
module sha2r_sigch_chk #(
  parameter int LANE_W = 64,
  parameter int ROT_A  = 14,
  parameter int ROT_B  = 18,
  parameter int ROT_C  = 41,
  localparam int WORD_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [WORD_W-1:0] inX,
  input logic [WORD_W-1:0] inY,
  input logic [WORD_W-1:0] inW,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData
);
  function automatic logic [LANE_W-1:0] rotr(input logic [LANE_W-1:0] v, input int n);
    return (v >> n) | (v << (LANE_W - n));
  endfunction

  function automatic logic [LANE_W-1:0] bigS1(input logic [LANE_W-1:0] v);
    return rotr(v, ROT_A) ^ rotr(v, ROT_B) ^ rotr(v, ROT_C);
  endfunction

  logic [LANE_W-1:0] expHi;
  always_comb begin
    expHi = ((inY[WORD_W-1:LANE_W] & inX[LANE_W-1:0]) |
             (~inY[WORD_W-1:LANE_W] & inX[WORD_W-1:LANE_W]))
            + bigS1(inY[WORD_W-1:LANE_W]) + inW[WORD_W-1:LANE_W];
  end

  logic prevRst;
  always_ff @(posedge clk) prevRst <= rst;

  always @(negedge clk) begin
    if (prevRst === 1'b1 && rst === 1'b0) begin
      AST_RESET_CLEARS: assert (outValid == 1'b0 && outData == '0); // R9
    end
  end

  AST_UPPER_LANE: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) ##1 outReady |=> outData[WORD_W-1:LANE_W] == $past(expHi, 2)); // R1

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) ##1 outReady |=> outValid); // R6

  AST_RISE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(outReady)); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !outValid ##1 !outValid |-> $stable(outData)); // R10
endmodule

bind sha2r_sigch_top sha2r_sigch_chk #(
  .LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C)
) u_sigch_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .inX(inX), .inY(inY), .inW(inW),
  .outValid(outValid), .outReady(outReady), .outData(outData)
);

// File: tb/test_sha2r_sigch_top.sv
`timescale 1ns/1ps
module test_sha2r_sigch_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inX = '0, inY = '0, inW = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [127:0] outData;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  sha2r_sigch_top i_sha2r_sigch_top (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .inW(inW),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  // Independent reference model.
  function automatic logic [63:0] ror64(input logic [63:0] v, input int n);
    return (v >> n) | (v << (64 - n));
  endfunction
  function automatic logic [63:0] s1(input logic [63:0] v);
    return ror64(v, 14) ^ ror64(v, 18) ^ ror64(v, 41);
  endfunction
  function automatic logic [127:0] model(input logic [127:0] x, y, w);
    logic [63:0] hi, t, lo;
    hi = ((y[127:64] & x[63:0]) ^ (~y[127:64] & x[127:64])) + s1(y[127:64]) + w[127:64];
    t  = hi + y[63:0];
    lo = ((t & y[127:64]) ^ (~t & x[63:0])) + s1(t) + w[63:0];
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; outReady = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Single operation with the consumer always ready.
  task automatic sendOne(input string req, input logic [127:0] x, y, w);
    @(negedge clk);
    inX = x; inY = y; inW = w; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, {127'd0, outValid}, 128'd1);
    check(req, outData, model(x, y, w));
  endtask

  task automatic testReset();
    check("R9 outValid after reset", {127'd0, outValid}, 128'd0);
    check("R9 outData after reset", outData, '0);
    check("R7 inReady follows outReady", {127'd0, inReady}, 128'd1);
  endtask

  task automatic testPatterns();
    sendOne("R1 R2 zeros", '0, '0, '0);
    sendOne("R3 selector ones", {64'h0123456789abcdef, 64'hfedcba9876543210},
            {64'hffffffffffffffff, 64'h0}, '0);
    sendOne("R3 selector mixed", {64'haaaaaaaa55555555, 64'h00ff00ff00ff00ff},
            {64'hf0f0f0f00f0f0f0f, 64'h1111111111111111}, {64'h5, 64'h7});
    sendOne("R4 tmp from y low", {64'h0, 64'hdeadbeefcafef00d},
            {64'h8000000000000001, 64'h7fffffffffffffff}, {64'h123, 64'h0});
    sendOne("R5 lane wrap", {64'hffffffffffffffff, 64'hffffffffffffffff},
            {64'h0, 64'hffffffffffffffff}, {64'hffffffffffffffff, 64'hffffffffffffffff});
    sendOne("R2 single bit", '0, {64'h1, 64'h0}, '0);
  endtask

  // Back-to-back stream, stall, release, bubble.
  task automatic testStream();
    logic [127:0] xa, ya, wa, xb, yb, wb;
    xa = {64'h1122334455667788, 64'h99aabbccddeeff00};
    ya = {64'h0f1e2d3c4b5a6978, 64'h8796a5b4c3d2e1f0};
    wa = {64'h428a2f98d728ae22, 64'h7137449123ef65cd};
    xb = {64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b};
    yb = {64'h510e527fade682d1, 64'h9b05688c2b3e6c1f};
    wb = {64'hb5c0fbcfec4d3b2f, 64'he9b5dba58189dbbc};
    @(negedge clk);
    inX = xa; inY = ya; inW = wa; inValid = 1'b1;
    @(negedge clk);
    inX = xb; inY = yb; inW = wb;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 first of stream", outData, model(xa, ya, wa));
    outReady = 1'b0;
    @(negedge clk);
    check("R8 stalled valid", {127'd0, outValid}, 128'd1);
    check("R8 stalled data", outData, model(xa, ya, wa));
    @(negedge clk);
    check("R8 stalled data later", outData, model(xa, ya, wa));
    outReady = 1'b1;
    @(negedge clk);
    check("R6 second of stream", outData, model(xb, yb, wb));
    check("R6 second valid", {127'd0, outValid}, 128'd1);
    @(negedge clk);
    check("R10 valid falls", {127'd0, outValid}, 128'd0);
    check("R10 data held", outData, model(xb, yb, wb));
  endtask

  task automatic testNoAccept();
    logic [127:0] held;
    held = outData;
    @(negedge clk);
    outReady = 1'b0;
    inX = '1; inY = '1; inW = '1; inValid = 1'b1;
    @(negedge clk);
    check("R7 inReady low", {127'd0, inReady}, 128'd0);
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 no ghost valid", {127'd0, outValid}, 128'd0);
    check("R7 no ghost data", outData, held);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    inX = {64'h3, 64'h4}; inY = {64'h5, 64'h6}; inW = {64'h7, 64'h8}; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 flush valid", {127'd0, outValid}, 128'd0);
    check("R9 flush data", outData, '0);
    @(negedge clk);
    check("R9 nothing after flush", {127'd0, outValid}, 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    doReset();
    testReset();
    testPatterns();
    testStream();
    testNoAccept();
    testMidReset();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule